// File: doc/BRIEF.md
# Bus Cycle Type Decoder with Lock Tracking

This block watches a processor's bus-definition lines alongside the active-low address strobe and ready inputs. It turns them into registered one-hot cycle-type strobes. The three definition lines are only meaningful while the strobe is low. The decode therefore ignores them at every other time, so the one combination that is never issued with the strobe is free for other use. If that combination does appear with the strobe low, the block raises an error flag instead of a strobe.

The block also drives an active-low lock output that covers a whole sequence of locked cycles. The bus is address-pipelined, so a new address can go out before the previous cycle's ready. The block counts outstanding cycles for this reason. A locked address issued behind unlocked cycles does not assert lock immediately. Lock asserts only once those earlier cycles have been retired. Lock then stays asserted until the core drops its lock request and the ready for the final locked cycle has arrived.

Usage rules for the core are as follows. While `lock_req` is high, every address it issues is a locked one. Once `lock_req` falls, it stays low until the lock output has been released. The core never issues more than `MAX_OUT` cycles that have not been retired. There is no data path and no back-pressure at this block's edge: every pin is a plain control or status signal sampled on each rising clock edge.

Top module: `buscyc_lockdec`

## Requirements
- R1: During and immediately after reset, `cyc_stb` is all zero, `rsv_err` is 0 and `lock_n` is 1.
- R2: When `ads_n` is low with a definition code c = {`def_mem`,`def_data`,`def_wr`} other than 3'b100, `cyc_stb` equals 1<<c in the following cycle only, and `rsv_err` stays 0.
- R3: When `ads_n` is high, `cyc_stb` is zero and `rsv_err` is 0 in the next cycle, whatever the definition lines carry, including 3'b100.
- R4: When `ads_n` is low with code 3'b100 (memory, control, read), `rsv_err` is 1 and `cyc_stb` is zero in the next cycle.
- R5: A locked address (`ads_n` low, `lock_req` high) issued with no earlier cycle outstanding drives `lock_n` low in the next cycle. This also holds when the only earlier outstanding cycle retires on that same edge.
- R6: A locked address issued behind N earlier unlocked cycles leaves `lock_n` high until the ready that retires the Nth of them. `lock_n` goes low in the cycle after that ready.
- R7: Once `lock_n` is low, it stays low for as long as `lock_req` is high, even with no cycle outstanding.
- R8: After `lock_req` falls, `lock_n` returns high in the cycle after the ready that retires the last locked cycle. Unlocked cycles issued after that cycle do not extend the lock.
- R9: A low `ready_n` while no cycle is outstanding has no effect on cycle tracking. A later locked address issued behind one unlocked cycle still waits for that cycle's ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ads_n | input | 1 | Address strobe, active low; marks a new bus cycle |
| ready_n | input | 1 | Ready, active low; retires the oldest outstanding cycle |
| def_wr | input | 1 | Definition line: 1 write, 0 read |
| def_data | input | 1 | Definition line: 1 data, 0 control |
| def_mem | input | 1 | Definition line: 1 memory, 0 I/O |
| lock_req | input | 1 | Core request that issued cycles be locked |
| cyc_stb | output | 8 | Registered one-hot cycle type, index {def_mem,def_data,def_wr} |
| rsv_err | output | 1 | Registered flag: reserved code seen with strobe low |
| lock_n | output | 1 | Bus lock output, active low |

## Verification
The bench sets `MAX_OUT` to 2. With a pipeline that shallow, random traffic keeps reaching the full-pipeline condition, and a locked address often lands behind one or two unlocked cycles. The bench therefore exercises the pending-lock path, and the case where ready and a locked address arrive on the same edge, many times over. Directed sequences cover each code with and without the strobe, stray readies on an empty pipeline, and lock release with unlocked cycles queued behind.

// File: rtl/buscyc_pkg.sv
package buscyc_pkg;

  // Definition code is {mem/io, data/control, write/read}.
  localparam int CODE_W    = 3;
  localparam int NUM_CODES = 1 << CODE_W;

  // Combination never issued with the strobe: memory, control, read.
  localparam logic [CODE_W-1:0] RSV_CODE = 3'b100;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_PEND = 2'd1,
    LK_HELD = 2'd2
  } lk_state_e;

endpackage

// File: rtl/buscyc_decode.sv
module buscyc_decode
  import buscyc_pkg::*;
#(
  parameter int W = CODE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ads_n,
  input  logic [W-1:0]         code,
  output logic [(1<<W)-1:0]    cyc_stb,
  output logic                 rsv_err
);

  localparam int N = 1 << W;

  logic [N-1:0] stb_w;

  // One flop per live code; the reserved slot is tied off.
  for (genvar i = 0; i < N; i++) begin : g_code
    if (W'(i) == RSV_CODE) begin : g_rsv
      assign stb_w[i] = 1'b0;
    end else begin : g_live
      logic hit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= !ads_n && (code == W'(i));
      end
      assign stb_w[i] = hit_q;
    end
  end

  logic rsv_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsv_q <= 1'b0;
    else        rsv_q <= !ads_n && (code == RSV_CODE);
  end

  assign cyc_stb = stb_w;
  assign rsv_err = rsv_q;

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cyc_stb, rsv_err})); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ads_n |=> (cyc_stb == '0 && !rsv_err)); // R3
  AST_RSV_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_n && code == RSV_CODE) |=> (rsv_err && cyc_stb == '0)); // R4

endmodule

// File: rtl/buscyc_track.sv
module buscyc_track #(
  parameter int MAX_OUT = 4,
  localparam int CW     = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          ready_n,
  output logic          retire,
  output logic [CW-1:0] ahead
);

  localparam logic [CW-1:0] FULL = CW'(MAX_OUT);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;

  // Ready with nothing outstanding is dropped here.
  assign retire = !ready_n && (cnt_q != '0);
  // Cycles still ahead of an address issued on this edge.
  assign ahead  = retire ? cnt_q - ONE : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      case ({issue, retire})
        2'b10:   cnt_q <= cnt_q + ONE;
        2'b01:   cnt_q <= cnt_q - ONE;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == FULL && issue) |-> retire); // R6
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL); // R9

endmodule

// File: rtl/buscyc_lock_fsm.sv
module buscyc_lock_fsm
  import buscyc_pkg::*;
#(
  parameter int MAX_OUT = 4,
  localparam int CW     = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          lock_req,
  input  logic          retire,
  input  logic [CW-1:0] ahead,
  output logic          lock_n
);

  localparam logic [CW-1:0] ONE = CW'(1);

  lk_state_e     state_q, state_d;
  logic [CW-1:0] wait_q, wait_d;   // unlocked cycles still ahead
  logic [CW-1:0] lkc_q, lkc_d;     // locked cycles not yet retired
  logic          lk_inc;

  assign lk_inc = issue && lock_req;

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    lkc_d   = lkc_q;
    unique case (state_q)
      LK_IDLE: begin
        if (lk_inc) begin
          lkc_d  = ONE;
          wait_d = ahead;
          state_d = (ahead == '0) ? LK_HELD : LK_PEND;
        end
      end
      LK_PEND: begin
        if (lk_inc) lkc_d = lkc_q + ONE;
        if (retire) begin
          wait_d = wait_q - ONE;
          if (wait_q == ONE) state_d = LK_HELD;
        end
      end
      LK_HELD: begin
        lkc_d = lkc_q;
        if (lk_inc) lkc_d = lkc_d + ONE;
        if (retire && lkc_q != '0) lkc_d = lkc_d - ONE;
        if (lkc_d == '0 && !lock_req) state_d = LK_IDLE;
      end
      default: state_d = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LK_IDLE;
      wait_q  <= '0;
      lkc_q   <= '0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      lkc_q   <= lkc_d;
    end
  end

  assign lock_n = (state_q != LK_HELD);

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_HELD && lock_req) |=> (state_q == LK_HELD)); // R7
  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_PEND) |-> (wait_q != '0 && lkc_q != '0)); // R6
  AST_PEND_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_PEND && !retire) |=> (state_q == LK_PEND)); // R6

endmodule

// File: rtl/buscyc_lockdec.sv
module buscyc_lockdec
  import buscyc_pkg::*;
#(
  parameter int MAX_OUT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ads_n,
  input  logic                 ready_n,
  input  logic                 def_wr,
  input  logic                 def_data,
  input  logic                 def_mem,
  input  logic                 lock_req,
  output logic [NUM_CODES-1:0] cyc_stb,
  output logic                 rsv_err,
  output logic                 lock_n
);

  localparam int CW = $clog2(MAX_OUT + 1);

  logic [CODE_W-1:0] code;
  logic              issue;
  logic              retire;
  logic [CW-1:0]     ahead;

  assign code  = {def_mem, def_data, def_wr};
  assign issue = !ads_n;

  buscyc_decode #(.W(CODE_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .ads_n   (ads_n),
    .code    (code),
    .cyc_stb (cyc_stb),
    .rsv_err (rsv_err)
  );

  buscyc_track #(.MAX_OUT(MAX_OUT)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .ready_n (ready_n),
    .retire  (retire),
    .ahead   (ahead)
  );

  buscyc_lock_fsm #(.MAX_OUT(MAX_OUT)) u_lk (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (issue),
    .lock_req (lock_req),
    .retire   (retire),
    .ahead    (ahead),
    .lock_n   (lock_n)
  );

  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_n) |-> !$past(lock_req)); // R8
  AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_n) |-> $past(lock_req) || $past(!ready_n)); // R5

endmodule

// File: tb/sim_buscyc_lockdec.sv
module sim_buscyc_lockdec;

  localparam int MAXO = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ads_n = 1'b1, ready_n = 1'b1;
  logic       def_wr = 1'b0, def_data = 1'b0, def_mem = 1'b0;
  logic       lock_req = 1'b0;
  logic [7:0] cyc_stb;
  logic       rsv_err, lock_n;

  always #10 clk = ~clk;

  buscyc_lockdec #(.MAX_OUT(MAXO)) u0 (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .ready_n(ready_n),
    .def_wr(def_wr), .def_data(def_data), .def_mem(def_mem),
    .lock_req(lock_req), .cyc_stb(cyc_stb), .rsv_err(rsv_err), .lock_n(lock_n)
  );

  int n_chk = 0, n_bad = 0;
  bit mq [0:7];
  int mqn = 0;
  bit m_locked = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit any_locked();
    for (int i = 0; i < mqn; i++) if (mq[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] exp_stb(bit ads, logic [2:0] c);
    return (ads && c != 3'b100) ? (8'd1 << c) : 8'd0;
  endfunction

  // One bus clock: drive at negedge, update model after posedge, compare at next negedge.
  task automatic cyc(bit ads, logic [2:0] c, bit lk, bit rdy, string tag);
    ads_n = !ads; {def_mem, def_data, def_wr} = c; lock_req = lk; ready_n = !rdy;
    @(posedge clk);
    if (rdy && mqn > 0) begin
      for (int i = 0; i < 7; i++) mq[i] = mq[i+1];
      mqn--;
    end
    if (ads) begin mq[mqn] = lk; mqn++; end
    if (m_locked) begin
      if (!lk && !any_locked()) m_locked = 0;
    end else if (mqn > 0 && mq[0]) m_locked = 1;
    @(negedge clk);
    chk({tag, " stb"}, cyc_stb, exp_stb(ads, c));
    chk({tag, " err"}, rsv_err, (ads && c == 3'b100));
    chk({tag, " lock"}, lock_n, !m_locked);
  endtask

  task automatic idle(int n, bit lk, string tag);
    for (int i = 0; i < n; i++) cyc(0, 3'b000, lk, 0, tag);
  endtask

  bit done = 0;

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 stb", cyc_stb, 0); chk("R1 err", rsv_err, 0); chk("R1 lock", lock_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post stb", cyc_stb, 0); chk("R1 post lock", lock_n, 1);

    // R2: every live code with strobe, retired by ready
    for (int c = 0; c < 8; c++) begin
      if (c == 4) continue;
      cyc(1, 3'(c), 0, 0, "R2");
      chk("R2 direct", cyc_stb, 8'd1 << c);
      cyc(0, 3'(c), 0, 1, "R2");
      chk("R2 one cycle", cyc_stb, 0);
    end
    // R3: idle definition lines, including reserved code
    for (int c = 0; c < 8; c++) cyc(0, 3'(c), 0, 0, "R3");
    // R4: reserved code with strobe
    cyc(1, 3'b100, 0, 0, "R4");
    chk("R4 direct", rsv_err, 1);
    cyc(0, 3'b000, 0, 1, "R4");

    // R5: locked address on empty pipeline
    cyc(1, 3'b110, 1, 0, "R5");
    chk("R5 direct", lock_n, 0);
    // R7: hold with nothing outstanding
    cyc(0, 3'b000, 1, 1, "R7");
    idle(3, 1, "R7");
    chk("R7 direct", lock_n, 0);
    cyc(0, 3'b000, 0, 0, "R8");
    chk("R8 release no outstanding", lock_n, 1);

    // R6: locked address behind two unlocked cycles
    cyc(1, 3'b110, 0, 0, "R6");
    cyc(1, 3'b111, 0, 0, "R6");
    cyc(0, 3'b000, 1, 0, "R6");
    cyc(1, 3'b111, 1, 1, "R6");
    chk("R6 pending", lock_n, 1);
    cyc(0, 3'b000, 1, 1, "R6");
    chk("R6 entry", lock_n, 0);
    // R8: drop request, queue an unlocked cycle behind, retire locked one
    cyc(1, 3'b110, 0, 0, "R8");
    chk("R8 still held", lock_n, 0);
    cyc(0, 3'b000, 0, 1, "R8");
    chk("R8 released", lock_n, 1);
    cyc(0, 3'b000, 0, 1, "R8");

    // R5: only earlier cycle retires on the locked edge
    cyc(1, 3'b010, 0, 0, "R5");
    cyc(1, 3'b111, 1, 1, "R5");
    chk("R5 same edge", lock_n, 0);
    cyc(0, 3'b000, 0, 1, "R5");
    chk("R5 end", lock_n, 1);

    // R9: stray readies, then locked behind one unlocked
    cyc(0, 3'b000, 0, 1, "R9");
    cyc(0, 3'b000, 0, 1, "R9");
    cyc(1, 3'b011, 0, 0, "R9");
    cyc(1, 3'b111, 1, 0, "R9");
    chk("R9 waits", lock_n, 1);
    cyc(0, 3'b000, 1, 1, "R9");
    chk("R9 entry", lock_n, 0);
    cyc(0, 3'b000, 0, 1, "R9");
    chk("R9 release", lock_n, 1);

    // Constrained random traffic
    begin
      bit rl = 0;
      for (int k = 0; k < 4000; k++) begin
        bit rdy, ads;
        logic [2:0] c;
        int room;
        if (rl && $urandom_range(7) == 0) rl = 0;
        else if (!rl && !m_locked && !any_locked() && $urandom_range(5) == 0) rl = 1;
        rdy  = ($urandom_range(2) != 0);
        room = mqn - ((rdy && mqn > 0) ? 1 : 0);
        ads  = ($urandom_range(1) == 1) && (room < MAXO);
        c    = 3'($urandom_range(7));
        cyc(ads, c, rl, rdy, ads ? ((c == 3'b100) ? "R4" : "R2") : "R3");
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule